// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block turns a fast master clock into the two clocks of a serial audio link: a bit clock and a frame (word-select) clock. Two integer ratios set the timing. The first is the number of master cycles per bit, chosen from {2, 4}. The second is the number of bits per frame, chosen from {32, 64, 128}. Software can program both ratios directly. It can also supply the ratio of master clock to sample rate and let the block choose both ratios itself.

Inside the block everything runs on the master clock. Besides the two clock levels, the block gives single-cycle strobes to the data path: one where data should change, one where data should be captured, and one that marks the end of each frame. Each clock level has its own polarity control. When continuous running is switched off, the bit clock is held idle during the bits of each half-frame slot that lie beyond the word length. A new ratio takes effect only at the next frame boundary, and disabling the block parks both clocks at their idle levels.

Top module: `audclk_gen`

## Requirements
- R1: With auto selection off, `bdiv_code`=0 gives 2 master cycles per bit and `bdiv_code`=1 gives 4. With polarity 0, the bit clock is low for the first half of each bit period (counted from enable) and high for the second half.
- R2: With auto selection off, `fdiv_code` picks the bits per frame: 0 gives 32, 1 gives 64, and 2 or 3 give 128.
- R3: With `auto_sel`=1 and `mclk_ratio` above 384, the block uses 4 master cycles per bit and 128 bits per frame, whatever the manual codes say.
- R4: With `auto_sel`=1 and `mclk_ratio` at most 384, the block uses 64 bits per frame. The bit ratio is 2 when `mclk_ratio` is below 192 and 4 otherwise, so auto selection never picks 32.
- R5: With polarity 0, the frame clock is low for the first half of the frame's bits and high for the second half. It changes level only on the capture (rising) edge of the bit clock, half a bit after the bit counter moves.
- R6: `launch_stb` is high in the last master cycle of each bit period. `sample_stb` is high in the cycle just before the bit clock rises. `frame_stb` is high together with the `launch_stb` of the last bit of a frame.
- R7: `bclk_inv`=1 inverts the bit clock and `fclk_inv`=1 inverts the frame clock. The strobes are not affected.
- R8: With `free_run`=0, the bit clock stays at its idle level for every bit whose position inside its half-frame slot is at or beyond the word length. `wlen_code` gives the word length: 0 is 16 bits, 1 is 24, and 2 or 3 is 32. With `free_run`=1, the bit clock toggles on every bit.
- R9: While `enable`=0, `bclk` equals `bclk_inv`, `fclk` equals `fclk_inv`, and all strobes are low. Each re-enable starts a fresh frame at bit 0 and phase 0.
- R10: A change of ratio codes (or of the auto inputs) made while running takes effect only after the current frame's last bit. The frame in progress finishes with its old timing.
- R11: During reset, both clocks sit at the levels given by their polarity inputs and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low parks the clocks and clears the counters |
| auto_sel | input | 1 | Choose the ratios from `mclk_ratio` instead of the codes |
| mclk_ratio | input | RATIO_W | Master clock cycles per sample |
| bdiv_code | input | 1 | Manual master-cycles-per-bit code |
| fdiv_code | input | 2 | Manual bits-per-frame code |
| wlen_code | input | 2 | Word length code, used for gating |
| free_run | input | 1 | Keep the bit clock toggling on every bit |
| bclk_inv | input | 1 | Bit clock polarity |
| fclk_inv | input | 1 | Frame clock polarity |
| bclk | output | 1 | Bit clock level |
| fclk | output | 1 | Frame clock level |
| launch_stb | output | 1 | Data-change strobe |
| sample_stb | output | 1 | Data-capture strobe |
| frame_stb | output | 1 | Last-bit-of-frame strobe |

## Verification
The hardest case to reach is a ratio change in the middle of a frame. From the ports alone, the held ratio cannot be told apart from the new one until the frame boundary has passed. The stimulus starts a short frame and changes both codes ten cycles into it. The expected stream keeps the old timing up to the wrap and then switches to the new ratios, with the frame clock still high from the old frame's second half. A further sequence drops `enable` in the middle of a frame to show that the counters restart at zero, and the auto cases sit exactly on and just past the 192 and 384 thresholds.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   typedef enum logic {
      BSEL_LO = 1'b0,
      BSEL_HI = 1'b1
   } bsel_e;

   typedef enum logic [1:0] {
      FSEL_SHORT = 2'd0,
      FSEL_MID   = 2'd1,
      FSEL_LONG  = 2'd2
   } fsel_e;

   function automatic fsel_e fsel_from_code(input logic [1:0] code);
      fsel_e r;
      case (code)
         2'd0:    r = FSEL_SHORT;
         2'd1:    r = FSEL_MID;
         default: r = FSEL_LONG;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/audclk_ratio_sel.sv
module audclk_ratio_sel
   import audclk_pkg::*;
#(
   parameter int RATIO_W = 12,
   parameter int AUTO_HI = 384,
   parameter int AUTO_LO = 192,
   parameter bit AUTO_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               auto_sel,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               bdiv_code,
   input  logic [1:0]         fdiv_code,
   output bsel_e              bsel_act,
   output fsel_e              fsel_act
);

   localparam logic [RATIO_W-1:0] HI_V = RATIO_W'(AUTO_HI);
   localparam logic [RATIO_W-1:0] LO_V = RATIO_W'(AUTO_LO);

   if (AUTO_LO >= AUTO_HI) begin : g_bad_thresh
      $error("audclk_ratio_sel: low threshold must be below high threshold");
   end
   if (AUTO_HI >= (1 << RATIO_W)) begin : g_bad_width
      $error("audclk_ratio_sel: ratio width too small for thresholds");
   end

   bsel_e bsel_man, bsel_req;
   fsel_e fsel_man, fsel_req;

   always_comb begin
      bsel_man = bdiv_code ? BSEL_HI : BSEL_LO;
      fsel_man = fsel_from_code(fdiv_code);
   end

   if (AUTO_EN) begin : g_auto
      bsel_e bsel_auto;
      fsel_e fsel_auto;
      always_comb begin
         if (ratio > HI_V) begin
            fsel_auto = FSEL_LONG;
            bsel_auto = BSEL_HI;
         end else begin
            fsel_auto = FSEL_MID;
            bsel_auto = (ratio < LO_V) ? BSEL_LO : BSEL_HI;
         end
         bsel_req = auto_sel ? bsel_auto : bsel_man;
         fsel_req = auto_sel ? fsel_auto : fsel_man;
      end

      a_r3_auto_long: assert property (@(posedge clk) disable iff (!rst_n)
         (load && auto_sel && ratio > HI_V) |=> (fsel_act == FSEL_LONG && bsel_act == BSEL_HI))
         else $error("a_r3_auto_long");
      a_r4_auto_mid: assert property (@(posedge clk) disable iff (!rst_n)
         (load && auto_sel && ratio <= HI_V) |=> (fsel_act == FSEL_MID))
         else $error("a_r4_auto_mid");
   end else begin : g_manual
      always_comb begin
         bsel_req = bsel_man;
         fsel_req = fsel_man;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bsel_act <= BSEL_LO;
         fsel_act <= FSEL_MID;
      end else if (load) begin
         bsel_act <= bsel_req;
         fsel_act <= fsel_req;
      end
   end

   // R10: the active ratios move only on a load (idle or frame wrap)
   a_r10_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(bsel_act) && $stable(fsel_act)))
      else $error("a_r10_hold_between_loads");

endmodule

// File: rtl/audclk_bit_timer.sv
module audclk_bit_timer
   import audclk_pkg::*;
#(
   parameter int BD_LO = 2,
   parameter int BD_HI = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  bsel_e bsel,
   output logic  rise_stb,
   output logic  fall_stb,
   output logic  bclk_lvl
);

   localparam int MCNT_W = $clog2(BD_HI);
   localparam logic [MCNT_W-1:0] LO_LAST = MCNT_W'(BD_LO - 1);
   localparam logic [MCNT_W-1:0] LO_MID  = MCNT_W'(BD_LO / 2 - 1);
   localparam logic [MCNT_W-1:0] HI_LAST = MCNT_W'(BD_HI - 1);
   localparam logic [MCNT_W-1:0] HI_MID  = MCNT_W'(BD_HI / 2 - 1);

   if (BD_LO < 2 || (BD_LO % 2) != 0) begin : g_bad_lo
      $error("audclk_bit_timer: low bit ratio must be even and at least 2");
   end
   if (BD_HI <= BD_LO || (BD_HI % 2) != 0) begin : g_bad_hi
      $error("audclk_bit_timer: high bit ratio must be even and above the low one");
   end

   logic [MCNT_W-1:0] mcnt;
   logic [MCNT_W-1:0] last_ph;
   logic [MCNT_W-1:0] mid_ph;

   always_comb begin
      last_ph  = (bsel == BSEL_HI) ? HI_LAST : LO_LAST;
      mid_ph   = (bsel == BSEL_HI) ? HI_MID  : LO_MID;
      rise_stb = en && (mcnt == mid_ph);
      fall_stb = en && (mcnt == last_ph);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt     <= '0;
         bclk_lvl <= 1'b0;
      end else if (!en) begin
         mcnt     <= '0;
         bclk_lvl <= 1'b0;
      end else begin
         mcnt <= fall_stb ? '0 : mcnt + 1'b1;
         if (rise_stb) begin
            bclk_lvl <= 1'b1;
         end else if (fall_stb) begin
            bclk_lvl <= 1'b0;
         end
      end
   end

   a_r1_high_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> bclk_lvl)
      else $error("a_r1_high_after_rise");
   a_r1_low_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !bclk_lvl)
      else $error("a_r1_low_after_fall");
   a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> !fall_stb)
      else $error("a_r6_strobes_apart");

endmodule

// File: rtl/audclk_frame_timer.sv
module audclk_frame_timer
   import audclk_pkg::*;
#(
   parameter int FD_S    = 32,
   parameter int FD_M    = 64,
   parameter int FD_L    = 128,
   parameter int WL_A    = 16,
   parameter int WL_B    = 24,
   parameter int WL_C    = 32,
   parameter bit GATE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  fsel_e      fsel,
   input  logic       rise_stb,
   input  logic       fall_stb,
   input  logic [1:0] wsel,
   input  logic       free_run,
   output logic       fclk_lvl,
   output logic       frame_wrap,
   output logic       in_word
);

   localparam int BCNT_W = $clog2(FD_L);
   localparam logic [BCNT_W-1:0] S_LAST = BCNT_W'(FD_S - 1);
   localparam logic [BCNT_W-1:0] M_LAST = BCNT_W'(FD_M - 1);
   localparam logic [BCNT_W-1:0] L_LAST = BCNT_W'(FD_L - 1);
   localparam logic [BCNT_W-1:0] S_HALF = BCNT_W'(FD_S / 2);
   localparam logic [BCNT_W-1:0] M_HALF = BCNT_W'(FD_M / 2);
   localparam logic [BCNT_W-1:0] L_HALF = BCNT_W'(FD_L / 2);

   if (FD_S < 4 || (FD_S & (FD_S - 1)) != 0 || FD_M <= FD_S ||
       (FD_M & (FD_M - 1)) != 0 || FD_L <= FD_M || (FD_L & (FD_L - 1)) != 0) begin : g_bad_fd
      $error("audclk_frame_timer: frame ratios must be rising powers of two");
   end
   if (WL_A > WL_B || WL_B > WL_C || WL_C >= FD_L) begin : g_bad_wl
      $error("audclk_frame_timer: word lengths must rise and stay below the long frame");
   end

   logic [BCNT_W-1:0] bcnt;
   logic [BCNT_W-1:0] last_bit;
   logic [BCNT_W-1:0] half_bit;

   always_comb begin
      case (fsel)
         FSEL_SHORT: begin
            last_bit = S_LAST;
            half_bit = S_HALF;
         end
         FSEL_MID: begin
            last_bit = M_LAST;
            half_bit = M_HALF;
         end
         default: begin
            last_bit = L_LAST;
            half_bit = L_HALF;
         end
      endcase
      frame_wrap = fall_stb && (bcnt == last_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt     <= '0;
         fclk_lvl <= 1'b0;
      end else if (!en) begin
         bcnt     <= '0;
         fclk_lvl <= 1'b0;
      end else begin
         if (fall_stb) begin
            bcnt <= (bcnt == last_bit) ? '0 : bcnt + 1'b1;
         end
         if (rise_stb) begin
            fclk_lvl <= (bcnt >= half_bit);
         end
      end
   end

   if (GATE_EN) begin : g_gate
      logic [BCNT_W-1:0] slot_pos;
      logic [BCNT_W-1:0] word_bits;
      always_comb begin
         case (wsel)
            2'd0:    word_bits = BCNT_W'(WL_A);
            2'd1:    word_bits = BCNT_W'(WL_B);
            default: word_bits = BCNT_W'(WL_C);
         endcase
         slot_pos = bcnt & (half_bit - 1'b1);
         in_word  = free_run || (slot_pos < word_bits);
      end
   end else begin : g_no_gate
      assign in_word = 1'b1;
   end

   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (bcnt <= last_bit))
      else $error("a_r2_count_range");
   a_r5_fclk_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rise_stb) |=> $stable(fclk_lvl))
      else $error("a_r5_fclk_on_rise_only");
   a_r9_cleared_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (bcnt == '0 && !fclk_lvl))
      else $error("a_r9_cleared_when_idle");

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
   import audclk_pkg::*;
#(
   parameter int RATIO_W = 12,
   parameter int BD_LO   = 2,
   parameter int BD_HI   = 4,
   parameter int FD_S    = 32,
   parameter int FD_M    = 64,
   parameter int FD_L    = 128,
   parameter int WL_A    = 16,
   parameter int WL_B    = 24,
   parameter int WL_C    = 32,
   parameter int AUTO_HI = 384,
   parameter int AUTO_LO = 192,
   parameter bit AUTO_EN = 1'b1,
   parameter bit GATE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               auto_sel,
   input  logic [RATIO_W-1:0] mclk_ratio,
   input  logic               bdiv_code,
   input  logic [1:0]         fdiv_code,
   input  logic [1:0]         wlen_code,
   input  logic               free_run,
   input  logic               bclk_inv,
   input  logic               fclk_inv,
   output logic               bclk,
   output logic               fclk,
   output logic               launch_stb,
   output logic               sample_stb,
   output logic               frame_stb
);

   bsel_e bsel_act;
   fsel_e fsel_act;
   logic  load;
   logic  rise_stb;
   logic  fall_stb;
   logic  bclk_lvl;
   logic  fclk_lvl;
   logic  frame_wrap;
   logic  in_word;

   assign load = !enable || frame_wrap;

   audclk_ratio_sel #(
      .RATIO_W (RATIO_W),
      .AUTO_HI (AUTO_HI),
      .AUTO_LO (AUTO_LO),
      .AUTO_EN (AUTO_EN)
   ) i_ratio_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .auto_sel  (auto_sel),
      .ratio     (mclk_ratio),
      .bdiv_code (bdiv_code),
      .fdiv_code (fdiv_code),
      .bsel_act  (bsel_act),
      .fsel_act  (fsel_act)
   );

   audclk_bit_timer #(
      .BD_LO (BD_LO),
      .BD_HI (BD_HI)
   ) i_bit_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .bsel     (bsel_act),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .bclk_lvl (bclk_lvl)
   );

   audclk_frame_timer #(
      .FD_S    (FD_S),
      .FD_M    (FD_M),
      .FD_L    (FD_L),
      .WL_A    (WL_A),
      .WL_B    (WL_B),
      .WL_C    (WL_C),
      .GATE_EN (GATE_EN)
   ) i_frame_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (enable),
      .fsel       (fsel_act),
      .rise_stb   (rise_stb),
      .fall_stb   (fall_stb),
      .wsel       (wlen_code),
      .free_run   (free_run),
      .fclk_lvl   (fclk_lvl),
      .frame_wrap (frame_wrap),
      .in_word    (in_word)
   );

   // R7, R8, R9: polarity, slot gating and idle parking at the pins
   assign bclk       = bclk_inv ^ (enable & bclk_lvl & in_word);
   assign fclk       = fclk_inv ^ (enable & fclk_lvl);
   assign launch_stb = fall_stb;
   assign sample_stb = rise_stb;
   assign frame_stb  = frame_wrap;

   a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!rise_stb && !fall_stb && !frame_wrap))
      else $error("a_r9_quiet_when_idle");
   a_r6_frame_with_launch: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wrap |-> fall_stb)
      else $error("a_r6_frame_with_launch");

endmodule

// File: tb/test_audclk_gen.sv
module test_audclk_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        auto_sel = 1'b0;
   logic [11:0] mclk_ratio = '0;
   logic        bdiv_code = 1'b0;
   logic [1:0]  fdiv_code = 2'd1;
   logic [1:0]  wlen_code = 2'd2;
   logic        free_run = 1'b1;
   logic        bclk_inv = 1'b0;
   logic        fclk_inv = 1'b0;
   logic        bclk, fclk, launch_stb, sample_stb, frame_stb;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [4:0] v;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   audclk_gen i_audclk_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .auto_sel   (auto_sel),
      .mclk_ratio (mclk_ratio),
      .bdiv_code  (bdiv_code),
      .fdiv_code  (fdiv_code),
      .wlen_code  (wlen_code),
      .free_run   (free_run),
      .bclk_inv   (bclk_inv),
      .fclk_inv   (fclk_inv),
      .bclk       (bclk),
      .fclk       (fclk),
      .launch_stb (launch_stb),
      .sample_stb (sample_stb),
      .frame_stb  (frame_stb)
   );

   task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got {bclk,fclk,launch,sample,frame}=%b expected=%b at %0t",
                  tag, got, exp, $time);
      end
   endtask

   // expected pins after n enabled edges, from the requirement timing
   function automatic logic [4:0] model(input int n, input int bd, input int fd, input int wb,
                                        input bit fr, input bit bp, input bit fp,
                                        input bit prevf, input bit en);
      int  mph, bitn, half;
      bit  blev, gate, flev, lau, sam, frm;
      if (!en) return {bp, fp, 3'b000};
      half = fd / 2;
      mph  = n % bd;
      bitn = (n / bd) % fd;
      lau  = (mph == bd - 1);
      sam  = (mph == bd / 2 - 1);
      frm  = lau && (bitn == fd - 1);
      blev = (mph >= bd / 2);
      gate = fr || ((bitn % half) < wb);
      if (n < bd / 2) flev = prevf;
      else flev = (((n - bd / 2) / bd) % fd) >= half;
      return {bp ^ (blev & gate), fp ^ flev, lau, sam, frm};
   endfunction

   function automatic int dec_bd(input bit au, input int ratio, input bit bc);
      if (au) return (ratio > 384) ? 4 : ((ratio < 192) ? 2 : 4);
      return bc ? 4 : 2;
   endfunction

   function automatic int dec_fd(input bit au, input int ratio, input int fc);
      if (au) return (ratio > 384) ? 128 : 64;
      return (fc == 0) ? 32 : ((fc == 1) ? 64 : 128);
   endfunction

   function automatic int dec_wb(input int wc);
      return (wc == 0) ? 16 : ((wc == 1) ? 24 : 32);
   endfunction

   task automatic push_items(input string tag, input int count, input int bd, input int fd,
                             input int wb, input bit fr, input bit bp, input bit fp,
                             input bit prevf, input bit en);
      for (int n = 0; n < count; n++) begin
         exp_t e;
         e.v   = model(n, bd, fd, wb, fr, bp, fp, prevf, en);
         e.tag = tag;
         q.push_back(e);
      end
   endtask

   // driver: called just after a rising edge; applies inputs, queues expectations, waits
   task automatic run_cfg(input string tag, input bit en, input bit au, input int ratio,
                          input bit bc, input int fc, input int wc, input bit fr,
                          input bit bp, input bit fp, input int ncyc);
      enable     = en;
      auto_sel   = au;
      mclk_ratio = 12'(ratio);
      bdiv_code  = bc;
      fdiv_code  = 2'(fc);
      wlen_code  = 2'(wc);
      free_run   = fr;
      bclk_inv   = bp;
      fclk_inv   = fp;
      push_items(tag, ncyc, dec_bd(au, ratio, bc), dec_fd(au, ratio, fc), dec_wb(wc),
                 fr, bp, fp, 1'b0, en);
      repeat (ncyc) @(posedge clk);
      #1;
   endtask

   task automatic session(input string tag, input bit au, input int ratio, input bit bc,
                          input int fc, input int wc, input bit fr, input bit bp,
                          input bit fp, input int ncyc);
      run_cfg({tag, " R9 idle"}, 1'b0, au, ratio, bc, fc, wc, fr, bp, fp, 2);
      run_cfg(tag, 1'b1, au, ratio, bc, fc, wc, fr, bp, fp, ncyc);
   endtask

   // monitor: compares the pins against the queued expectation every falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, {bclk, fclk, launch_stb, sample_stb, frame_stb}, e.v);
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   initial begin
      // R11: reset state, both polarities
      #15;
      check("R11 reset idle", {bclk, fclk, launch_stb, sample_stb, frame_stb}, 5'b00000);
      bclk_inv = 1'b1;
      fclk_inv = 1'b1;
      #20;
      check("R11 reset inverted", {bclk, fclk, launch_stb, sample_stb, frame_stb}, 5'b11000);
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R1 R2 R5 R6: two cycles per bit, 64-bit frame, two frames
      session("R1 R2 R5 R6 bd2 fd64", 1'b0, 0, 1'b0, 1, 2, 1'b0, 1'b0, 1'b0, 256);
      // R7 R1: four cycles per bit, 32-bit frame, both polarities inverted
      session("R7 R1 bd4 fd32 inv", 1'b0, 0, 1'b1, 0, 2, 1'b1, 1'b1, 1'b1, 256);
      // R8 R2: code 3 gives 128 bits, 16-bit words gated
      session("R8 R2 wlen16 fd128", 1'b0, 0, 1'b0, 3, 0, 1'b0, 1'b0, 1'b0, 260);
      // R8: 24-bit words in a 64-bit frame
      session("R8 wlen24 fd64", 1'b0, 0, 1'b0, 1, 1, 1'b0, 1'b0, 1'b0, 130);
      // R8 R2: free running overrides short word, code 2 gives 128 bits
      session("R8 R2 free fd128", 1'b0, 0, 1'b1, 2, 0, 1'b1, 1'b0, 1'b0, 520);

      // R4 R3: automatic choice with contrary manual codes
      session("R4 auto ratio100", 1'b1, 100, 1'b1, 0, 2, 1'b1, 1'b0, 1'b0, 140);
      session("R4 auto ratio191", 1'b1, 191, 1'b1, 0, 2, 1'b1, 1'b0, 1'b0, 140);
      session("R4 auto ratio192", 1'b1, 192, 1'b0, 0, 2, 1'b1, 1'b0, 1'b0, 270);
      session("R4 auto ratio384", 1'b1, 384, 1'b0, 0, 2, 1'b1, 1'b0, 1'b0, 270);
      session("R3 auto ratio385", 1'b1, 385, 1'b0, 0, 2, 1'b1, 1'b0, 1'b0, 530);
      session("R3 auto ratio4000", 1'b1, 4000, 1'b0, 1, 2, 1'b1, 1'b0, 1'b0, 520);

      // R9: drop enable mid-frame, then restart from bit 0
      session("R9 before drop", 1'b0, 0, 1'b0, 1, 2, 1'b1, 1'b0, 1'b1, 50);
      run_cfg("R9 dropped", 1'b0, 1'b0, 0, 1'b0, 1, 2, 1'b1, 1'b0, 1'b1, 3);
      run_cfg("R9 restart", 1'b1, 1'b0, 0, 1'b0, 1, 2, 1'b1, 1'b0, 1'b1, 100);

      // R10: ratio change mid-frame applies at the wrap only
      run_cfg("R10 idle", 1'b0, 1'b0, 0, 1'b0, 0, 2, 1'b1, 1'b0, 1'b0, 2);
      push_items("R10 old frame", 64, 2, 32, 32, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      push_items("R10 new ratios", 300, 4, 64, 32, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      enable = 1'b1;
      repeat (10) @(posedge clk);
      #1;
      bdiv_code = 1'b1;
      fdiv_code = 2'd1;
      repeat (354) @(posedge clk);
      #1;
      enable = 1'b0;

      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      finish_run();
   end

endmodule